// File: doc/BRIEF.md
# Shared-Channel Interrupt Source Router

This block takes a wide vector of level-sensitive device interrupt lines and folds them onto a small set of CPU interrupt channels. Each source has its own map register. The register names the one channel the source drives, or holds the unconnected code so that the source drives nothing. Any number of sources may share one channel. A channel output is the OR of the active sources mapped to it. Software services a shared channel by asking the router which of the sources on that channel to handle first. The answer is always the lowest-numbered active source.

A bank of NMI select registers, each holding a source number, feeds one non-maskable interrupt output. Writes to that bank are accepted only from protection context zero. A subset of the low channels is also brought out as deep-sleep wakeup lines. All control pins are plain level or strobe signals. There is no valid/ready handshake and no back-pressure: a write or a query strobe is taken on the clock edge where it is high.

Top module: `irq_router`

## Requirements
- R1: After reset, every map register reads back as the unconnected code (channel field all ones, 15 by default). Every NMI select holds the disconnected code (source field all ones, 127 by default). `ch_irq`, `ch_wake` and `nmi_o` are low, and `act_src` equals the disconnected code.
- R2: A write with `wr_sel`=0 and `wr_idx` below NUM_SRC loads the low CH_IDX_W bits of `wr_data` into that source's map register. The new value reads back on `map_rd_ch` from the next cycle. Writing the all-ones value of the channel field unconnects the source.
- R3: `ch_irq[c]` is high in the same cycle whenever at least one active source holds the value c in its map register. A map value of NUM_CH or more (software-only channel indices 8 to 14, or the unconnected code) drives no output.
- R4: When `rd_en` is high at a clock edge, `act_src` takes, one cycle later, the lowest-numbered active source mapped to `rd_ch`. While `rd_en` is low, `act_src` holds its value.
- R5: A query finds no active mapped source, or names a channel of NUM_CH or more. In either case `act_src` becomes the disconnected code.
- R6: `ch_wake[c]` follows `ch_irq[c]` for c below WAKE_CH (2 by default) and is always low for the higher channels.
- R7: `nmi_o` is high in the same cycle whenever any NMI select holds the number of an active source. A select holding the disconnected code contributes nothing. Writes with `wr_sel`=1 and `wr_idx` below NUM_NMI load the full `wr_data`.
- R8: A write with `wr_sel`=1 while `wr_prot` is nonzero leaves every NMI select unchanged.
- R9: A write whose `wr_idx` is out of range for its target (NUM_SRC or more for maps, NUM_NMI or more for NMI selects) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | NUM_SRC | Level-sensitive device interrupt lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 source map, 1 NMI select |
| wr_idx | input | SRC_W | Source number or NMI select number to write |
| wr_data | input | SRC_W | Channel (low CH_IDX_W bits) or source number |
| wr_prot | input | PROT_W | Protection context of the writer |
| map_rd_idx | input | SRC_W | Source whose map register is read back |
| map_rd_ch | output | CH_IDX_W | Map register of `map_rd_idx`, unconnected code if out of range |
| rd_en | input | 1 | Active-source query strobe |
| rd_ch | input | CH_IDX_W | Channel to query |
| act_src | output | SRC_W | Registered query result |
| ch_irq | output | NUM_CH | Hardware channel interrupt outputs |
| ch_wake | output | NUM_CH | Deep-sleep wakeup outputs |
| nmi_o | output | 1 | Non-maskable interrupt output |

## Verification
The properties assume the inputs are at known levels at every clock edge after reset. They also assume that `src_irq` is the only thing that can raise a channel or the NMI, which holds because no other input feeds those outputs in the same cycle. The stimulus changes inputs only a short time after each rising edge. It runs a directed phase first: shared channel 3 with sources 29 and 46, an unmapped query, a software-only mapping, and NMI writes from blocked and allowed contexts. A random phase follows, with sparse interrupt patterns and mixed in-range and out-of-range writes. A behavioural model tracks every register and output and compares them on each falling edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic {
    TGT_MAP = 1'b0,
    TGT_NMI = 1'b1
  } wr_target_e;
endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs #(
  parameter int NUM_SRC  = 64,
  parameter int SRC_W    = 7,
  parameter int CH_IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SRC_W-1:0]            wr_idx,
  input  logic [CH_IDX_W-1:0]         wr_ch,
  output logic [NUM_SRC*CH_IDX_W-1:0] map_flat
);
  localparam logic [CH_IDX_W-1:0] UNCONN = '1;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [CH_IDX_W-1:0] map_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q <= UNCONN;
      else if (wr_en && wr_idx == SRC_W'(s))
        map_q <= wr_ch;
    end
    assign map_flat[s*CH_IDX_W +: CH_IDX_W] = map_q;
  end
endmodule

// File: rtl/irq_chan_route.sv
module irq_chan_route #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CH   = 8,
  parameter int SRC_W    = 7,
  parameter int CH_IDX_W = 4
) (
  input  logic [NUM_SRC*CH_IDX_W-1:0] map_flat,
  input  logic [NUM_SRC-1:0]          src_irq,
  input  logic [CH_IDX_W-1:0]         qry_ch,
  output logic [NUM_CH-1:0]           ch_irq,
  output logic [SRC_W-1:0]            qry_hit
);
  localparam logic [SRC_W-1:0]    DISC    = '1;
  localparam logic [CH_IDX_W-1:0] NCH_LIM = CH_IDX_W'(NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      ch_irq[c] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (src_irq[s] && map_flat[s*CH_IDX_W +: CH_IDX_W] == CH_IDX_W'(c))
          ch_irq[c] = 1'b1;
    end
  end

  // Lowest-index priority encoder over the sources on the queried channel
  always_comb begin
    qry_hit = DISC;
    if (qry_ch < NCH_LIM) begin
      for (int s = NUM_SRC - 1; s >= 0; s--)
        if (src_irq[s] && map_flat[s*CH_IDX_W +: CH_IDX_W] == qry_ch)
          qry_hit = SRC_W'(s);
    end
  end
endmodule

// File: rtl/irq_nmi_sel.sv
module irq_nmi_sel #(
  parameter int NUM_SRC = 64,
  parameter int NUM_NMI = 4,
  parameter int SRC_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SRC_W-1:0]   wr_idx,
  input  logic [SRC_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0] src_irq,
  output logic               nmi
);
  localparam logic [SRC_W-1:0] DISC = '1;

  logic [NUM_NMI-1:0] hit;

  for (genvar k = 0; k < NUM_NMI; k++) begin : g_sel
    logic [SRC_W-1:0] sel_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q <= DISC;
      else if (wr_en && wr_idx == SRC_W'(k))
        sel_q <= wr_data;
    end
    always_comb begin
      hit[k] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (sel_q == SRC_W'(s) && src_irq[s])
          hit[k] = 1'b1;
    end
  end

  assign nmi = |hit;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CH   = 8,
  parameter int CH_IDX_W = 4,
  parameter int WAKE_CH  = 2,
  parameter int NUM_NMI  = 4,
  parameter int PROT_W   = 2,
  parameter int SRC_W    = $clog2(NUM_SRC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_irq,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [SRC_W-1:0]    wr_idx,
  input  logic [SRC_W-1:0]    wr_data,
  input  logic [PROT_W-1:0]   wr_prot,
  input  logic [SRC_W-1:0]    map_rd_idx,
  output logic [CH_IDX_W-1:0] map_rd_ch,
  input  logic                rd_en,
  input  logic [CH_IDX_W-1:0] rd_ch,
  output logic [SRC_W-1:0]    act_src,
  output logic [NUM_CH-1:0]   ch_irq,
  output logic [NUM_CH-1:0]   ch_wake,
  output logic                nmi_o
);
  localparam logic [SRC_W-1:0]    DISC   = '1;
  localparam logic [CH_IDX_W-1:0] UNCONN = '1;

  logic [NUM_SRC*CH_IDX_W-1:0] map_flat;
  logic [SRC_W-1:0]            qry_hit;
  logic                        map_we;
  logic                        nmi_we;

  assign map_we = wr_en && (wr_target_e'(wr_sel) == TGT_MAP);
  assign nmi_we = wr_en && (wr_target_e'(wr_sel) == TGT_NMI) && (wr_prot == '0);

  irq_map_regs #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CH_IDX_W(CH_IDX_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_idx(wr_idx),
    .wr_ch(wr_data[CH_IDX_W-1:0]), .map_flat(map_flat)
  );

  irq_chan_route #(
    .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SRC_W(SRC_W), .CH_IDX_W(CH_IDX_W)
  ) u_route (
    .map_flat(map_flat), .src_irq(src_irq), .qry_ch(rd_ch),
    .ch_irq(ch_irq), .qry_hit(qry_hit)
  );

  irq_nmi_sel #(
    .NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .SRC_W(SRC_W)
  ) u_nmi (
    .clk(clk), .rst_n(rst_n), .wr_en(nmi_we), .wr_idx(wr_idx),
    .wr_data(wr_data), .src_irq(src_irq), .nmi(nmi_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_src <= DISC;
    else if (rd_en)
      act_src <= qry_hit;
  end

  always_comb begin
    map_rd_ch = UNCONN;
    for (int s = 0; s < NUM_SRC; s++)
      if (map_rd_idx == SRC_W'(s))
        map_rd_ch = map_flat[s*CH_IDX_W +: CH_IDX_W];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wake
    if (c < WAKE_CH) begin : g_on
      assign ch_wake[c] = ch_irq[c];
    end else begin : g_off
      assign ch_wake[c] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CH  = 8,
  parameter int WAKE_CH = 2,
  parameter int SRC_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_irq,
  input logic               rd_en,
  input logic [SRC_W-1:0]   act_src,
  input logic [NUM_CH-1:0]  ch_irq,
  input logic [NUM_CH-1:0]  ch_wake,
  input logic               nmi_o
);
  localparam logic [SRC_W-1:0]  DISC      = '1;
  localparam logic [NUM_CH-1:0] WAKE_MASK = NUM_CH'((1 << WAKE_CH) - 1);

  assert_quiet_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |-> (ch_irq == '0));

  assert_act_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(act_src));

  assert_empty_query_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && src_irq == '0) |=> (act_src == DISC));

  assert_wake_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wake & ~WAKE_MASK) == '0);

  assert_wake_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wake != '0) |-> ((ch_wake & ~ch_irq) == '0));

  assert_quiet_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |-> !nmi_o);
endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .WAKE_CH(WAKE_CH), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .rd_en(rd_en),
  .act_src(act_src), .ch_irq(ch_irq), .ch_wake(ch_wake), .nmi_o(nmi_o)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  localparam int NSRC = 64;
  localparam int NCH  = 8;
  localparam int CHW  = 4;
  localparam int WAKE = 2;
  localparam int NNMI = 4;
  localparam int PW   = 2;
  localparam int SW   = 7;
  localparam int DISC = 127;
  localparam int UNC  = 15;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [NSRC-1:0] src_irq = '0;
  logic            wr_en = 0, wr_sel = 0, rd_en = 0;
  logic [SW-1:0]   wr_idx = '0, wr_data = '0, map_rd_idx = '0;
  logic [PW-1:0]   wr_prot = '0;
  logic [CHW-1:0]  rd_ch = '0;
  logic [CHW-1:0]  map_rd_ch;
  logic [SW-1:0]   act_src;
  logic [NCH-1:0]  ch_irq, ch_wake;
  logic            nmi_o;

  int checks = 0, errors = 0;
  int mp [NSRC];
  int ns [NNMI];
  int act;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router #(.NUM_SRC(NSRC), .NUM_CH(NCH), .CH_IDX_W(CHW), .WAKE_CH(WAKE),
               .NUM_NMI(NNMI), .PROT_W(PW)) u_irq_router (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_prot(wr_prot), .map_rd_idx(map_rd_idx),
    .map_rd_ch(map_rd_ch), .rd_en(rd_en), .rd_ch(rd_ch), .act_src(act_src),
    .ch_irq(ch_irq), .ch_wake(ch_wake), .nmi_o(nmi_o));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int m_query(int ch);
    if (ch >= NCH) return DISC;
    for (int s = 0; s < NSRC; s++)
      if (src_irq[s] && mp[s] == ch) return s;
    return DISC;
  endfunction

  function automatic int m_chan();
    int v = 0;
    for (int s = 0; s < NSRC; s++)
      if (src_irq[s] && mp[s] < NCH) v |= (1 << mp[s]);
    return v;
  endfunction

  function automatic int m_nmi();
    for (int k = 0; k < NNMI; k++)
      if (ns[k] < NSRC && src_irq[ns[k]]) return 1;
    return 0;
  endfunction

  // Reference model state update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) mp[s] = UNC;
      for (int k = 0; k < NNMI; k++) ns[k] = DISC;
      act = DISC;
    end else begin
      if (rd_en) act = m_query(int'(rd_ch));
      if (wr_en && !wr_sel && int'(wr_idx) < NSRC) mp[wr_idx] = int'(wr_data) & UNC;
      if (wr_en && wr_sel && wr_prot == 0 && int'(wr_idx) < NNMI) ns[wr_idx] = int'(wr_data);
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 map readback", int'(map_rd_ch),
          (int'(map_rd_idx) < NSRC) ? mp[map_rd_idx] : UNC);
      chk("R3 channel outputs", int'(ch_irq), m_chan());
      chk("R6 wake outputs", int'(ch_wake), m_chan() & ((1 << WAKE) - 1));
      chk("R7/R8 nmi output", int'(nmi_o), m_nmi());
      chk("R4/R5 active source", int'(act_src), act);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(bit sel, int idx, int data, int pc);
    wr_en = 1; wr_sel = sel; wr_idx = SW'(idx); wr_data = SW'(data); wr_prot = PW'(pc);
    tick();
  endtask

  task automatic query(int ch);
    rd_en = 1; rd_ch = CHW'(ch);
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 map unconnected", int'(map_rd_ch), UNC);
    chk("R1 act_src", int'(act_src), DISC);
    chk("R1 channels idle", int'(ch_irq), 0);
    chk("R1 nmi idle", int'(nmi_o), 0);
    #2;
    wr(0, 29, 3, 0); wr(0, 46, 3, 0); wr(0, 5, 0, 0);
    wr(0, 60, 1, 0); wr(0, 10, 9, 0); wr(0, 63, 7, 0);
    map_rd_idx = 29;
    @(negedge clk); chk("R2 map of 29", int'(map_rd_ch), 3);
    #2;
    src_irq[46] = 1; query(3);
    @(negedge clk); chk("R4 shared ch3 single", int'(act_src), 46);
    #2;
    src_irq[29] = 1; query(3);
    @(negedge clk); chk("R4 lowest wins", int'(act_src), 29);
    chk("R3 ch3 high", int'(ch_irq[3]), 1);
    #2;
    src_irq[10] = 1; query(9);
    @(negedge clk); chk("R5 software channel query", int'(act_src), DISC);
    chk("R3 software mapping drives none", int'(ch_irq), 8);
    #2;
    wr(0, 29, UNC, 0); query(3);
    @(negedge clk); chk("R2 unmapped source dropped", int'(act_src), 46);
    #2;
    src_irq = '0; query(3);
    @(negedge clk); chk("R5 nothing pending", int'(act_src), DISC);
    #2;
    src_irq[5] = 1; src_irq[60] = 1;
    @(negedge clk); chk("R6 wake ch0/ch1", int'(ch_wake), 3);
    #2;
    src_irq[63] = 1;
    @(negedge clk); chk("R6 no wake on ch7", int'(ch_wake[7]), 0);
    #2;
    wr(1, 0, 5, 1);
    @(negedge clk); chk("R8 blocked nmi write", int'(nmi_o), 0);
    #2;
    wr(1, 5, 5, 0);
    @(negedge clk); chk("R9 nmi index out of range", int'(nmi_o), 0);
    #2;
    wr(1, 2, 5, 0);
    @(negedge clk); chk("R7 nmi selected", int'(nmi_o), 1);
    #2;
    wr(1, 2, DISC, 0);
    @(negedge clk); chk("R7 nmi disconnected", int'(nmi_o), 0);
    #2;
    wr(0, 70, 3, 0); map_rd_idx = 6;
    @(negedge clk); chk("R9 map index out of range", int'(map_rd_ch), UNC);
    #2;
    for (int i = 0; i < 400; i++) begin
      src_irq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      map_rd_idx = SW'($urandom_range(0, 70));
      wr_en = ($urandom_range(0, 2) == 0);
      wr_sel = $urandom_range(0, 1);
      wr_idx = SW'(wr_sel ? $urandom_range(0, 5) : $urandom_range(0, 68));
      wr_data = SW'(($urandom_range(0, 7) == 0) ? DISC :
                    (wr_sel ? $urandom_range(0, 63) : $urandom_range(0, 10)));
      wr_prot = PW'(($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 3));
      rd_en = $urandom_range(0, 1);
      rd_ch = CHW'($urandom_range(0, 9));
      @(posedge clk); #2;
    end
    wr_en = 0; rd_en = 0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    done = 1;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule